// File: doc/BRIEF.md
# UART Line Status Error Tracker

This block produces the transmitter-idle bit, the aggregate receive-error bit and the per-cause receive error flags of a UART line status register. It watches three things: whether the transmit holding register and the transmit shift register are empty, a strobe that marks a character moving from the receiver into the receive holding register together with that character's error flags, and a one-cycle strobe for each CPU read of the status register.

The aggregate error bit and the per-cause flags are sticky. A transfer carrying an error sets them, and a status read clears them, even if erroneous characters are still queued behind. In legacy single-character mode the aggregate bit is held at zero. In 9-bit framing the parity flag is ignored, because parity is not used there. Every output is registered, so each result appears one clock after the inputs that cause it.

Top module: `uart_lsr_status`

## Requirements
- R1: While reset is high and on the first cycle after it, `tx_idle` is 1, `err_any` is 0 and `err_flags` is 0.
- R2: One cycle after a cycle in which both `thr_empty` and `tsr_empty` are 1, `tx_idle` is 1.
- R3: One cycle after a cycle in which `thr_empty` or `tsr_empty` is 0, `tx_idle` is 0.
- R4: When the mode is not legacy, a cycle with `rx_xfer`=1 and a qualifying error flag sets `err_any` in the next cycle. Framing (`rx_flags[1]`) and break (`rx_flags[2]`) always qualify. Parity (`rx_flags[0]`) qualifies except in 9-bit mode.
- R5: A cycle with `stat_rd`=1 and no qualifying erroneous transfer clears `err_any` and all `err_flags` bits in the next cycle.
- R6: When `stat_rd` and a qualifying erroneous transfer fall in the same cycle, the set wins. `err_any` and the flags of that transfer are 1 in the next cycle.
- R7: In legacy mode (`mode`=2'b00), `err_any` is 0 one cycle after any cycle spent in that mode.
- R8: In 9-bit mode (`mode`=2'b10), a transfer with only `rx_flags[0]` set changes neither `err_any` nor `err_flags[0]`.
- R9: Each bit of `err_flags` (bit 0 parity, bit 1 framing, bit 2 break) is set by a transfer carrying that qualifying flag. It stays set until a status read, independent of the mode.
- R10: Without a read, a transfer with no qualifying flags, or an idle cycle, leaves `err_any` and `err_flags` unchanged.
- R11: Modes 2'b01 and 2'b11 both behave as standard FIFO mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 legacy, 01/11 FIFO, 10 9-bit framing |
| thr_empty | input | 1 | Transmit holding register is empty |
| tsr_empty | input | 1 | Shift register empty and last character fully sent |
| rx_xfer | input | 1 | Character moved into the receive holding register this cycle |
| rx_flags | input | 3 | Flags of that character: bit0 parity, bit1 framing, bit2 break |
| stat_rd | input | 1 | One-cycle pulse, CPU reads the status register |
| tx_idle | output | 1 | Transmitter fully idle |
| err_any | output | 1 | Aggregate receive error bit |
| err_flags | output | 3 | Sticky per-cause error flags, same bit order as `rx_flags` |

## Verification
Every output comes from one register stage, so each result is due exactly one clock edge after the input cycle that causes it. The bench drives inputs just after a falling edge. From those inputs it computes the next expected state, then compares the outputs at the following falling edge, after the single rising edge has updated them. Directed sequences cover read-and-set collisions, switching into legacy mode and parity-only transfers in 9-bit mode. A seeded random phase mixes all the inputs, and each check is tagged with the requirement its situation exercises.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  localparam int FLAG_W   = 3;
  localparam int FLAG_PAR = 0;
  localparam int FLAG_FRM = 1;
  localparam int FLAG_BRK = 2;

  typedef enum logic [1:0] {
    MODE_LEGACY   = 2'b00,
    MODE_FIFO     = 2'b01,
    MODE_NINE     = 2'b10,
    MODE_FIFO_ALT = 2'b11
  } lsr_mode_e;
endpackage

// File: rtl/lsr_tx_idle.sv
module lsr_tx_idle (
  input  logic clk,
  input  logic rst,
  input  logic hold_empty,
  input  logic shift_empty,
  output logic idle
);
  always_ff @(posedge clk) begin
    if (rst) idle <= 1'b1;
    else     idle <= hold_empty & shift_empty;
  end
endmodule

// File: rtl/lsr_flag_qual.sv
module lsr_flag_qual
  import uart_lsr_pkg::*;
#(
  parameter int W = FLAG_W
) (
  input  lsr_mode_e      mode,
  input  logic           xfer,
  input  logic [W-1:0]   flags_in,
  output logic [W-1:0]   flags_set,
  output logic           any_set
);
  logic [W-1:0] mask;

  always_comb begin
    mask = '1;
    if (mode == MODE_NINE) mask[FLAG_PAR] = 1'b0;
  end

  assign flags_set = xfer ? (flags_in & mask) : '0;
  assign any_set   = |flags_set;
endmodule

// File: rtl/lsr_sticky_bit.sv
module lsr_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_low,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || hold_low) q <= 1'b0;
    else if (set_i)      q <= 1'b1;
    else if (clr_i)      q <= 1'b0;
  end
endmodule

// File: rtl/uart_lsr_status.sv
module uart_lsr_status
  import uart_lsr_pkg::*;
#(
  parameter int NFLAG = FLAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             thr_empty,
  input  logic             tsr_empty,
  input  logic             rx_xfer,
  input  logic [NFLAG-1:0] rx_flags,
  input  logic             stat_rd,
  output logic             tx_idle,
  output logic             err_any,
  output logic [NFLAG-1:0] err_flags
);
  lsr_mode_e        mode_e;
  logic [NFLAG-1:0] q_flags;
  logic             q_any;
  logic             legacy;

  assign mode_e = lsr_mode_e'(mode);
  assign legacy = (mode_e == MODE_LEGACY);

  lsr_tx_idle u_idle (
    .clk(clk), .rst(rst),
    .hold_empty(thr_empty), .shift_empty(tsr_empty),
    .idle(tx_idle)
  );

  lsr_flag_qual #(.W(NFLAG)) u_qual (
    .mode(mode_e), .xfer(rx_xfer), .flags_in(rx_flags),
    .flags_set(q_flags), .any_set(q_any)
  );

  // Per-cause sticky flags: unaffected by legacy mode
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    lsr_sticky_bit u_bit (
      .clk(clk), .rst(rst),
      .set_i(q_flags[i]), .clr_i(stat_rd), .hold_low(1'b0),
      .q(err_flags[i])
    );
  end

  // Aggregate bit: pinned low in legacy mode
  lsr_sticky_bit u_any (
    .clk(clk), .rst(rst),
    .set_i(q_any), .clr_i(stat_rd), .hold_low(legacy),
    .q(err_any)
  );
endmodule

// File: rtl/uart_lsr_status_chk.sv
module uart_lsr_status_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       thr_empty,
  input logic       tsr_empty,
  input logic       rx_xfer,
  input logic [2:0] rx_flags,
  input logic       stat_rd,
  input logic       tx_idle,
  input logic       err_any,
  input logic [2:0] err_flags
);
  // R2
  idle_set_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_empty && tsr_empty) |=> tx_idle);
  // R3
  idle_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !(thr_empty && tsr_empty) |=> !tx_idle);
  // R4
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b00 && rx_xfer && (rx_flags[1] || rx_flags[2])) |=> err_any);
  // R5
  err_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !rx_xfer) |=> (!err_any && err_flags == 3'b000));
  // R7
  legacy_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> !err_any);
  // R8
  nine_par_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && rx_xfer && rx_flags == 3'b001 && !stat_rd)
      |=> ($stable(err_any) && $stable(err_flags[0])));
  // R9
  frm_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_xfer && rx_flags[1]) |=> err_flags[1]);
endmodule

bind uart_lsr_status uart_lsr_status_chk u_chk (.*);

// File: tb/uart_lsr_status_test.sv
`timescale 1ns/1ps
module uart_lsr_status_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode;
  logic       thr_empty, tsr_empty, rx_xfer, stat_rd;
  logic [2:0] rx_flags;
  logic       tx_idle, err_any;
  logic [2:0] err_flags;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic       e_idle, e_any;
  logic [2:0] e_flags;

  always #2.5 clk = ~clk;

  uart_lsr_status uut (
    .clk(clk), .rst(rst), .mode(mode), .thr_empty(thr_empty),
    .tsr_empty(tsr_empty), .rx_xfer(rx_xfer), .rx_flags(rx_flags),
    .stat_rd(stat_rd), .tx_idle(tx_idle), .err_any(err_any),
    .err_flags(err_flags)
  );

  function automatic logic [2:0] qual(input logic [1:0] m, input logic x,
                                      input logic [2:0] f);
    logic [2:0] r;
    r = x ? f : 3'b000;
    if (m == 2'b10) r[0] = 1'b0;
    return r;
  endfunction

  // compute expected state after one edge from current drives
  task automatic step_model();
    logic [2:0] q;
    q = qual(mode, rx_xfer, rx_flags);
    e_idle = thr_empty & tsr_empty;
    for (int i = 0; i < 3; i++)
      if (q[i]) e_flags[i] = 1'b1;
      else if (stat_rd) e_flags[i] = 1'b0;
    if (mode == 2'b00) e_any = 1'b0;
    else if (|q) e_any = 1'b1;
    else if (stat_rd) e_any = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string any_tag();
    logic [2:0] q;
    q = qual(mode, rx_xfer, rx_flags);
    if (mode == 2'b00) return "R7";
    if (stat_rd && |q) return "R6";
    if (|q) return (mode == 2'b11) ? "R11" : "R4";
    if (stat_rd) return "R5";
    if (mode == 2'b10 && rx_xfer && rx_flags[0]) return "R8";
    return "R10";
  endfunction

  task automatic cyc(input logic [1:0] m, input logic te, input logic se,
                     input logic x, input logic [2:0] f, input logic rd);
    string t;
    mode = m; thr_empty = te; tsr_empty = se;
    rx_xfer = x; rx_flags = f; stat_rd = rd;
    t = any_tag();
    step_model();
    @(negedge clk);
    chk((te && se) ? "R2" : "R3", {4'b0, tx_idle}, {4'b0, e_idle});
    chk(t, {4'b0, err_any}, {4'b0, e_any});
    chk((t == "R5" || t == "R6" || t == "R8") ? t : "R9",
        {2'b0, err_flags}, {2'b0, e_flags});
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [31:0] r;
    r = $urandom(32'd1234);
    rst = 1'b1; mode = 2'b01; thr_empty = 1'b0; tsr_empty = 1'b0;
    rx_xfer = 1'b0; rx_flags = 3'b000; stat_rd = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", {tx_idle, err_any, err_flags}, 5'b10000);
    rst = 1'b0;
    e_idle = 1'b1; e_any = 1'b0; e_flags = 3'b000;
    thr_empty = 1'b1; tsr_empty = 1'b1;
    @(negedge clk);
    // R1 first cycle after reset
    chk("R1", {tx_idle, err_any, err_flags}, 5'b10000);

    // directed: busy then idle (R3, R2)
    cyc(2'b01, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0);
    cyc(2'b01, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0);
    cyc(2'b01, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0);
    // R4 framing, hold (R10), read clear (R5)
    cyc(2'b01, 1'b1, 1'b1, 1'b1, 3'b010, 1'b0);
    cyc(2'b01, 1'b1, 1'b1, 1'b1, 3'b000, 1'b0);
    cyc(2'b01, 1'b1, 1'b1, 1'b0, 3'b000, 1'b1);
    // R6 read colliding with a break transfer
    cyc(2'b01, 1'b1, 1'b1, 1'b1, 3'b100, 1'b1);
    // R8 parity ignored in 9-bit mode
    cyc(2'b10, 1'b1, 1'b1, 1'b0, 3'b000, 1'b1);
    cyc(2'b10, 1'b1, 1'b1, 1'b1, 3'b001, 1'b0);
    // R4 parity counts in FIFO mode; R11 alt encoding
    cyc(2'b01, 1'b1, 1'b1, 1'b1, 3'b001, 1'b0);
    cyc(2'b11, 1'b1, 1'b1, 1'b0, 3'b000, 1'b1);
    cyc(2'b11, 1'b1, 1'b1, 1'b1, 3'b001, 1'b0);
    // R7 legacy pins aggregate low, flags (R9) still latch
    cyc(2'b00, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0);
    cyc(2'b00, 1'b1, 1'b1, 1'b1, 3'b110, 1'b0);
    cyc(2'b01, 1'b1, 1'b1, 1'b0, 3'b000, 1'b1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] v;
      v = $urandom;
      cyc(v[1:0], v[2] | v[3], v[4] | v[5], v[6] & v[7],
          v[10:8] & {v[11], v[12], v[13]}, (v[15:14] == 2'b00));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule